// File: doc/BRIEF.md
# Prefetching Block Address Sequencer

This block turns a stream of operand requests into byte addresses for a large read-only memory organised as 64-byte blocks of eight 8-byte quadwords. Each request carries a 64-bit word from the execution side. One cycle later the block answers with the address of the quadword to read. It also presents the address of the block that follows, so a memory controller can start fetching that block one block in advance.

Three registers hold the state: a quadword pointer, a next-block pointer and a 64-bit mixing register. Every request folds its input word into the mixing register with XOR. When the ten low bits of the result are all zero, the next-block pointer is redirected to a block address taken from the mixing register. Otherwise reading continues sequentially. With random inputs a redirect happens roughly once every 1024 requests. A synchronous load with a 32-bit seed starts a new run.

A small controller with three named states sequences the work. `ST_UNINIT` is entered at reset and ignores requests. `ST_IDLE` means the block is loaded and no response is pending. `ST_ISSUE` is the response cycle. The transitions are:
- load: any state to `ST_IDLE` when `init` is high.
- accept: `ST_IDLE` or `ST_ISSUE` to `ST_ISSUE` when `req` is high and `init` is low.
- drain: `ST_ISSUE` to `ST_IDLE` when neither input is high.
- hold: every other combination leaves the state as it is.

Top module: `blkaddr_seq`

## Requirements
- R1: After reset, `rsp_valid`, `rd_addr` and `prefetch_addr` are all zero.
- R2: Before the first `init`, a request produces no response, leaves `prefetch_addr` unchanged and does not alter the mixing register.
- R3: `init` loads three values: the quadword pointer becomes `seed` with bits 5:0 cleared, the next-block pointer becomes that value plus 64 (mod 2^32), and the mixing register becomes 0. `prefetch_addr` shows the new next-block pointer in the following cycle.
- R4: An accepted request raises `rsp_valid` for exactly the next cycle. In that cycle `rd_addr` carries the quadword pointer value from the accepting cycle, with bits 2:0 equal to zero.
- R5: Within a block, each accepted request advances the quadword pointer by 8, giving eight quadwords per block.
- R6: Each accepted request updates the mixing register as mix = mix XOR addr_in, accumulating across requests.
- R7: If bits 9:0 of the updated mixing register are zero, the next-block pointer takes bits 41:10 of it with bits 5:0 cleared. This is visible on `prefetch_addr` the next cycle, and the pointer is always a multiple of 64.
- R8: The request that returns the quadword at byte offset 56 of a block (the eighth) moves the quadword pointer to the next-block pointer, including a redirect made by that same request. It then sets the next-block pointer to that address plus 64.
- R9: Sequential block advance wraps modulo 2^32.
- R10: `init` takes priority over a request in the same cycle; that request gets no response and the state restarts from the seed.
- R11: Requests on consecutive cycles each get their own response, and `rsp_valid` returns to 0 in the first cycle after the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| init | input | 1 | Load initial register values from `seed` |
| seed | input | 32 | Start address for a run |
| req | input | 1 | Operand request, one per cycle |
| addr_in | input | 64 | Word folded into the mixing register |
| rsp_valid | output | 1 | Response cycle for the previous request |
| rd_addr | output | 32 | Byte address of the quadword to read |
| prefetch_addr | output | 32 | Address of the block to fetch next |

## Verification
The bench builds the block with its default parameters: 32-bit pointers, a 64-bit mixing register, a 10-bit zero test and 64-byte blocks of 8-byte quadwords. A redirect would almost never come from random inputs, so the bench chooses `addr_in` values that clear the low ten mixing bits on purpose. This reaches redirects on the first request, in the middle of a block and through accumulation over two requests. A seed just below the top of the address space brings the 2^32 wrap of both pointers into reach within a few blocks.

// File: rtl/blkaddr_seq_pkg.sv
package blkaddr_seq_pkg;
    typedef enum logic [1:0] {
        ST_UNINIT = 2'd0,
        ST_IDLE   = 2'd1,
        ST_ISSUE  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/blkaddr_seq_ctrl.sv
module blkaddr_seq_ctrl
    import blkaddr_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic init,
    input  logic req,
    output logic accept,
    output logic load_init,
    output logic rsp_valid
);
    seq_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_UNINIT;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNINIT: if (init) state_d = ST_IDLE;
            ST_IDLE: begin
                if (init)     state_d = ST_IDLE;
                else if (req) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (init)     state_d = ST_IDLE;
                else if (req) state_d = ST_ISSUE;
                else          state_d = ST_IDLE;
            end
            default: state_d = ST_UNINIT;
        endcase
    end

    // outputs
    always_comb begin
        load_init = init;
        accept    = req && !init && (state_q != ST_UNINIT);
        rsp_valid = (state_q == ST_ISSUE);
    end

    assert_uninit_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_UNINIT) |=> !rsp_valid);
    assert_rsp_follows_R4: assert property (@(posedge clk) disable iff (rst)
        accept |=> rsp_valid);
    assert_rsp_drops_R11: assert property (@(posedge clk) disable iff (rst)
        !accept |=> !rsp_valid);
endmodule

// File: rtl/blkaddr_seq_mix.sv
module blkaddr_seq_mix #(
    parameter int AW        = 32,
    parameter int MW        = 64,
    parameter int ZB        = 10,
    parameter int BLK_BYTES = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_init,
    input  logic          accept,
    input  logic [MW-1:0] addr_in,
    output logic          jump,
    output logic [AW-1:0] jump_tgt
);
    localparam int BSH = $clog2(BLK_BYTES);

    logic [MW-1:0] mix_q, mix_upd;

    always_comb begin
        mix_upd  = mix_q ^ addr_in;
        jump     = accept && (mix_upd[ZB-1:0] == '0);
        jump_tgt = {mix_upd[ZB+AW-1:ZB+BSH], {BSH{1'b0}}};
    end

    always_ff @(posedge clk) begin
        if (rst)            mix_q <= '0;
        else if (load_init) mix_q <= '0;
        else if (accept)    mix_q <= mix_upd;
    end

    assert_mix_fold_R6: assert property (@(posedge clk) disable iff (rst)
        (accept && !load_init) |=> (mix_q == ($past(mix_q) ^ $past(addr_in))));
    assert_mix_cleared_R3: assert property (@(posedge clk) disable iff (rst)
        load_init |=> (mix_q == '0));
    assert_mix_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (!accept && !load_init) |=> $stable(mix_q));
endmodule

// File: rtl/blkaddr_seq_ptr.sv
module blkaddr_seq_ptr #(
    parameter int AW        = 32,
    parameter int QW_BYTES  = 8,
    parameter int BLK_BYTES = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_init,
    input  logic          accept,
    input  logic          jump,
    input  logic [AW-1:0] seed,
    input  logic [AW-1:0] jump_tgt,
    output logic [AW-1:0] rd_addr,
    output logic [AW-1:0] blk_addr
);
    localparam int QSH = $clog2(QW_BYTES);
    localparam int BSH = $clog2(BLK_BYTES);
    localparam logic [AW-1:0] QW_STEP  = AW'(QW_BYTES);
    localparam logic [AW-1:0] BLK_STEP = AW'(BLK_BYTES);
    localparam logic [AW-1:0] BLK_MASK = ~(BLK_STEP - 1'b1);

    logic [AW-1:0] qw_q, blk_q, rd_q;
    logic [AW-1:0] seed_base, blk_eff;
    logic          last_qw;

    always_comb begin
        seed_base = seed & BLK_MASK;
        blk_eff   = jump ? jump_tgt : blk_q;
        last_qw   = &qw_q[BSH-1:QSH];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            qw_q  <= '0;
            blk_q <= '0;
            rd_q  <= '0;
        end else if (load_init) begin
            qw_q  <= seed_base;
            blk_q <= seed_base + BLK_STEP;
        end else if (accept) begin
            rd_q <= qw_q;
            if (last_qw) begin
                qw_q  <= blk_eff;
                blk_q <= blk_eff + BLK_STEP;
            end else begin
                qw_q  <= qw_q + QW_STEP;
                blk_q <= blk_eff;
            end
        end
    end

    assign rd_addr  = rd_q;
    assign blk_addr = blk_q;

    assert_init_load_R3: assert property (@(posedge clk) disable iff (rst)
        load_init |=> (blk_q == qw_q + BLK_STEP));
    assert_rd_value_R4: assert property (@(posedge clk) disable iff (rst)
        accept |=> (rd_addr == $past(qw_q) && rd_addr[QSH-1:0] == '0));
    assert_seq_step_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && !last_qw) |=> (qw_q == $past(qw_q) + QW_STEP));
    assert_blk_aligned_R7: assert property (@(posedge clk) disable iff (rst)
        blk_q[BSH-1:0] == '0);
    assert_mid_jump_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && jump && !last_qw) |=> (blk_q == $past(jump_tgt)));
    assert_boundary_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && last_qw) |=> (blk_q == qw_q + BLK_STEP));
endmodule

// File: rtl/blkaddr_seq.sv
module blkaddr_seq #(
    parameter int AW        = 32,
    parameter int MW        = 64,
    parameter int ZB        = 10,
    parameter int QW_BYTES  = 8,
    parameter int BLK_BYTES = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          init,
    input  logic [AW-1:0] seed,
    input  logic          req,
    input  logic [MW-1:0] addr_in,
    output logic          rsp_valid,
    output logic [AW-1:0] rd_addr,
    output logic [AW-1:0] prefetch_addr
);
    logic          accept, load_init, jump;
    logic [AW-1:0] jump_tgt;

    blkaddr_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .init      (init),
        .req       (req),
        .accept    (accept),
        .load_init (load_init),
        .rsp_valid (rsp_valid)
    );

    blkaddr_seq_mix #(.AW(AW), .MW(MW), .ZB(ZB), .BLK_BYTES(BLK_BYTES)) u_mix (
        .clk       (clk),
        .rst       (rst),
        .load_init (load_init),
        .accept    (accept),
        .addr_in   (addr_in),
        .jump      (jump),
        .jump_tgt  (jump_tgt)
    );

    blkaddr_seq_ptr #(.AW(AW), .QW_BYTES(QW_BYTES), .BLK_BYTES(BLK_BYTES)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .load_init (load_init),
        .accept    (accept),
        .jump      (jump),
        .seed      (seed),
        .jump_tgt  (jump_tgt),
        .rd_addr   (rd_addr),
        .blk_addr  (prefetch_addr)
    );

    assert_prefetch_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!accept && !load_init) |=> $stable(prefetch_addr));
endmodule

// File: tb/blkaddr_seq_tb.sv
module blkaddr_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init = 1'b0;
    logic [31:0] seed = '0;
    logic        req = 1'b0;
    logic [63:0] addr_in = '0;
    logic        rsp_valid;
    logic [31:0] rd_addr, prefetch_addr;

    int n_checks = 0;
    int n_err = 0;

    logic [31:0] m_qw, m_blk;
    logic [63:0] m_mix;

    always #5 clk = ~clk;

    blkaddr_seq dut_i (
        .clk(clk), .rst(rst), .init(init), .seed(seed), .req(req),
        .addr_in(addr_in), .rsp_valid(rsp_valid), .rd_addr(rd_addr),
        .prefetch_addr(prefetch_addr)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_init(input logic [31:0] s);
        m_qw  = {s[31:6], 6'b0};
        m_blk = m_qw + 32'd64;
        m_mix = '0;
    endtask

    task automatic model_req(input logic [63:0] a, output logic [31:0] exp_rd);
        logic [63:0] mu;
        logic [31:0] eff;
        exp_rd = m_qw;
        mu  = m_mix ^ a;
        eff = (mu[9:0] == 10'd0) ? {mu[41:16], 6'b0} : m_blk;
        if (m_qw[5:3] == 3'd7) begin
            m_qw  = eff;
            m_blk = eff + 32'd64;
        end else begin
            m_qw  = m_qw + 32'd8;
            m_blk = eff;
        end
        m_mix = mu;
    endtask

    task automatic do_init(input logic [31:0] s, input string tag);
        init = 1'b1;
        seed = s;
        @(posedge clk);
        @(negedge clk);
        init = 1'b0;
        model_init(s);
        check({tag, " prefetch after init"}, 64'(prefetch_addr), 64'(m_blk));
        check({tag, " no response on init"}, 64'(rsp_valid), 64'd0);
    endtask

    task automatic do_req(input logic [63:0] a, input string tag);
        logic [31:0] exp_rd;
        req = 1'b1;
        addr_in = a;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        model_req(a, exp_rd);
        check({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        check({tag, " rd_addr"}, 64'(rd_addr), 64'(exp_rd));
        check({tag, " prefetch"}, 64'(prefetch_addr), 64'(m_blk));
    endtask

    task automatic t_reset;
        check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        check("R1 rd_addr", 64'(rd_addr), 64'd0);
        check("R1 prefetch", 64'(prefetch_addr), 64'd0);
    endtask

    task automatic t_uninit;
        req = 1'b1;
        addr_in = 64'h0000_0000_0000_0155;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        check("R2 no response before init", 64'(rsp_valid), 64'd0);
        check("R2 prefetch unchanged", 64'(prefetch_addr), 64'd0);
        do_init(32'h1000_0000, "R2");
        // mix still 0: 0x400 gives a redirect to block 0
        do_req(64'h0000_0000_0000_0400, "R2 mix untouched");
        check("R2 redirect target", 64'(prefetch_addr), 64'd0);
    endtask

    task automatic t_init;
        do_init(32'h1234_5677, "R3");
        check("R3 explicit prefetch", 64'(prefetch_addr), 64'h1234_5680);
        do_req(64'd1, "R3 first request");
        check("R3 explicit rd_addr", 64'(rd_addr), 64'h1234_5640);
    endtask

    task automatic t_seq;
        do_init(32'h0000_2000, "R5");
        for (int i = 0; i < 8; i++) begin
            do_req((i == 0) ? 64'd1 : 64'd0, "R5 sequential");
            check("R5 step", 64'(rd_addr), 64'h2000 + 64'(8 * i));
            check("R4 aligned", 64'(rd_addr[2:0]), 64'd0);
        end
        do_req(64'd0, "R8 next block");
        check("R8 rd is old next-block", 64'(rd_addr), 64'h2040);
        check("R8 prefetch advanced", 64'(prefetch_addr), 64'h2080);
    endtask

    task automatic t_jump;
        do_init(32'h4000_0000, "R7");
        do_req(64'h0000_0123_4567_8000, "R7 redirect");
        check("R7 target", 64'(prefetch_addr), 64'h48D1_59C0);
        for (int i = 0; i < 7; i++) do_req(64'd0, "R7 rest of block");
        do_req(64'd3, "R8 after redirect");
        check("R8 rd at target", 64'(rd_addr), 64'h48D1_59C0);
        do_init(32'h0000_8000, "R6");
        do_req(64'hFFFF_0000_0000_0001, "R6 first fold");
        check("R6 no redirect yet", 64'(prefetch_addr), 64'h8040);
        do_req(64'hFFFF_0000_0003_2401, "R6 second fold");
        check("R6 accumulated redirect", 64'(prefetch_addr), 64'h0000_00C0);
        for (int i = 0; i < 5; i++) do_req(64'd1 << (i + 12), "R6 fill");
        do_req(64'h0000_0000_0003_0000, "R8 redirect on eighth");
        check("R8 same-request redirect", 64'(prefetch_addr), m_blk);
    endtask

    task automatic t_wrap;
        do_init(32'hFFFF_FF80, "R9");
        for (int i = 0; i < 8; i++) do_req((i == 0) ? 64'd1 : 64'd0, "R9 block A");
        check("R9 prefetch wrapped", 64'(prefetch_addr), 64'd0);
        for (int i = 0; i < 8; i++) do_req(64'd0, "R9 block B");
        check("R9 last rd", 64'(rd_addr), 64'hFFFF_FFF8);
        do_req(64'd0, "R9 block C");
        check("R9 rd at zero", 64'(rd_addr), 64'd0);
        check("R9 prefetch after wrap", 64'(prefetch_addr), 64'h40);
    endtask

    task automatic t_init_prio;
        do_init(32'h0300_0000, "R10");
        for (int i = 0; i < 3; i++) do_req(64'd7, "R10 partial block");
        req = 1'b1;
        init = 1'b1;
        seed = 32'h2000_0000;
        addr_in = 64'd5;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        init = 1'b0;
        model_init(32'h2000_0000);
        check("R10 no response", 64'(rsp_valid), 64'd0);
        check("R10 prefetch from seed", 64'(prefetch_addr), 64'h2000_0040);
        do_req(64'd1, "R10 restart");
        check("R10 rd from seed", 64'(rd_addr), 64'h2000_0000);
    endtask

    task automatic t_burst;
        do_init(32'h0055_0000, "R11");
        for (int i = 0; i < 4; i++) do_req(64'h11 + 64'(i), "R11 back-to-back");
        @(posedge clk);
        @(negedge clk);
        check("R11 rsp_valid drops", 64'(rsp_valid), 64'd0);
        check("R4 rd holds", 64'(rd_addr), 64'h0055_0018);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_uninit();
        t_init();
        t_seq();
        t_jump();
        t_wrap();
        t_init_prio();
        t_burst();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule